// File: doc/BRIEF.md
# Register Access Command Framer

This block runs register read and write transactions towards a MAC-PHY over a full-duplex byte link. A host-side request names the operation, a 4-bit memory map selector, a 16-bit register address and a register count. The framer then drives the byte link. It sends a header word first, then the write data words (or zero bytes for a read), then one word of zero filler. All words go out most-significant byte first.

Every transmitted byte slot also returns one byte. The reply runs four bytes behind the request. The framer compares the returned stream against what it sent four slots earlier. For a write it compares the whole header and every data word. For a read it compares only the header, and it then assembles the bytes that follow into read data words. The transaction ends with a one-cycle done pulse, with a protocol-error flag valid in that same cycle. A request whose register count is out of range is refused at once and no byte moves.

The byte link uses a valid/ready handshake. The framer holds `xfer_valid_o` and `tx_byte_o`. An exchange completes on a rising clock edge where `xfer_ready_i` is also high, and `rx_byte_i` is the byte received for that slot. Write words are taken from `wdata_i` in the cycle when their first byte is exchanged, and `wdata_take_o` marks that cycle.

Top module: `reg_cmd_framer`

## Requirements
- R1: The header word carries bit 31 = 0, bits 30 and 28 = 0, bit 29 = 1 for a write and 0 for a read, the selector in bits 27:24, the address in bits 23:8, and the register count minus one in bits 7:1.
- R2: Header bit 0 is set so that the 32-bit header word has an odd number of ones.
- R3: A transaction of N registers exchanges exactly 4*(N+2) bytes: header, N data words, one filler word. Every word is sent most-significant byte first, and the filler bytes are zero.
- R4: A request with a count of 0 or above 128 gives `done_o` and `err_o` high in the following cycle. `busy_o` stays low and no byte is exchanged.
- R5: For a write, data word k goes out in byte slots 4+4k to 7+4k. `wdata_take_o` is high exactly once per data word, in the handshake cycle of that word's first byte.
- R6: For a read, every byte after the header, data slots and filler alike, is transmitted as zero.
- R7: For a write, received byte i (i >= 4) must equal the byte sent in slot i-4. Any mismatch sets `err_o` with `done_o`.
- R8: Received bytes 0 to 3 are ignored. For a read, only received bytes 4 to 7, the echoed header, are compared, so corrupt data bytes raise no error.
- R9: For a read, received bytes 8 onward form N words, most-significant byte first. Each word is presented on `rdata_o` with a one-cycle `rdata_valid_o` pulse.
- R10: `busy_o` is high from acceptance until the done pulse. Requests offered while busy are ignored. `done_o` pulses once per transaction, and `err_o` is high only together with `done_o`.
- R11: While `xfer_valid_o` is high and `xfer_ready_i` is low, `xfer_valid_o` and `tx_byte_o` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered; accepted when not busy |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_mms_i | input | 4 | Memory map selector |
| req_addr_i | input | 16 | First register address |
| req_count_i | input | CNT_W | Number of registers (1 to CNT_MAX) |
| wdata_i | input | 32 | Current write data word |
| wdata_take_o | output | 1 | `wdata_i` consumed this cycle |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Protocol error or refused request, valid with `done_o` |
| rdata_o | output | 32 | Read data word |
| rdata_valid_o | output | 1 | `rdata_o` valid pulse |
| xfer_valid_o | output | 1 | Byte exchange requested |
| xfer_ready_i | input | 1 | Byte exchange completes on this edge |
| tx_byte_o | output | 8 | Byte to send |
| rx_byte_i | input | 8 | Byte received in the same slot |

## Verification
The bench builds the framer with its default parameters, CNT_W = 8 and CNT_MAX = 128. With these values a full 128-register read of 520 bytes can be run, and so can counts of 0, 129 and 255, which the port can carry but which must be refused. A bench peer echoes each transmitted byte four slots later, and it can invert any one chosen reply slot. This places corruption in the ignored lead bytes, the echoed header, a write data echo or a read data word. A stalling ready pattern exercises the hold rule on the byte handshake.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;

  // control header word with odd total parity in bit 0
  function automatic logic [WORD_W-1:0] make_hdr(input logic wr, input logic [3:0] mms,
                                                 input logic [15:0] addr, input logic [6:0] cnt_m1);
    logic [WORD_W-1:0] h;
    h = {1'b0, 1'b0, wr, 1'b0, mms, addr, cnt_m1, 1'b0};
    h[0] = ~(^h[WORD_W-1:1]);
    return h;
  endfunction
endpackage

// File: rtl/rcf_hdr_gen.sv
module rcf_hdr_gen
  import rcf_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             wr_i,
  input  logic [3:0]       mms_i,
  input  logic [15:0]      addr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [WORD_W-1:0] hdr_o
);
  logic [CNT_W-1:0] cnt_m1;
  assign cnt_m1 = cnt_i - CNT_W'(1);
  assign hdr_o  = make_hdr(wr_i, mms_i, addr_i, cnt_m1[6:0]);
endmodule

// File: rtl/rcf_echo_chk.sv
module rcf_echo_chk
  import rcf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              hs_i,
  input  logic              chk_i,
  input  logic [BYTE_W-1:0] tx_i,
  input  logic [BYTE_W-1:0] rx_i,
  output logic              err_o
);
  logic [WORD_W-1:0] hist_q;
  logic              err_q;
  logic              miss;

  // hist_q[31:24] is the byte sent four handshakes ago
  assign miss  = hs_i && chk_i && (rx_i != hist_q[WORD_W-1 -: BYTE_W]);
  assign err_o = err_q | miss;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      err_q  <= 1'b0;
    end else if (clr_i) begin
      hist_q <= '0;
      err_q  <= 1'b0;
    end else if (hs_i) begin
      hist_q <= {hist_q[WORD_W-BYTE_W-1:0], tx_i};
      err_q  <= err_o;
    end
  end
endmodule

// File: rtl/rcf_rd_collect.sv
module rcf_rd_collect
  import rcf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              word_end_i,
  input  logic [BYTE_W-1:0] rx_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  logic [WORD_W-BYTE_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (en_i) begin
        sh_q <= {sh_q[WORD_W-2*BYTE_W-1:0], rx_i};
        if (word_end_i) begin
          word_o  <= {sh_q, rx_i};
          valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/reg_cmd_framer.sv
module reg_cmd_framer
  import rcf_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int CNT_MAX = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [3:0]        req_mms_i,
  input  logic [15:0]       req_addr_i,
  input  logic [CNT_W-1:0]  req_count_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              wdata_take_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rdata_valid_o,
  output logic              xfer_valid_o,
  input  logic              xfer_ready_i,
  output logic [BYTE_W-1:0] tx_byte_o,
  input  logic [BYTE_W-1:0] rx_byte_i
);
  localparam int IDX_W = CNT_W + 3;

  logic              busy_q, wr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] hdr_q, word_q, hdr_w;
  logic [IDX_W-1:0]  idx_q, total, data_end;
  logic [1:0]        pos;
  logic              acc, cnt_ok, hs, in_hdr, in_data, last, take, chk_en, chk_err;

  assign acc      = req_valid_i && !busy_q;
  assign cnt_ok   = (req_count_i != '0) && (int'(req_count_i) <= CNT_MAX);
  assign hs       = busy_q && xfer_ready_i;
  assign pos      = idx_q[1:0];
  assign total    = IDX_W'({cnt_q, 2'b00}) + IDX_W'(8);
  assign data_end = total - IDX_W'(4);
  assign in_hdr   = idx_q < IDX_W'(4);
  assign in_data  = !in_hdr && (idx_q < data_end);
  assign last     = idx_q == total - IDX_W'(1);
  assign take     = hs && wr_q && in_data && (pos == 2'd0);
  // writes echo everything; reads echo only the header
  assign chk_en   = !in_hdr && (wr_q || idx_q < IDX_W'(8));

  always_comb begin
    tx_byte_o = '0;
    if (in_hdr)
      tx_byte_o = hdr_q[8*(3-pos) +: 8];
    else if (in_data && wr_q)
      tx_byte_o = (pos == 2'd0) ? wdata_i[WORD_W-1 -: BYTE_W] : word_q[8*(3-pos) +: 8];
  end

  assign xfer_valid_o = busy_q;
  assign busy_o       = busy_q;
  assign wdata_take_o = take;

  rcf_hdr_gen #(.CNT_W(CNT_W)) u_hdr (
    .wr_i(req_write_i), .mms_i(req_mms_i), .addr_i(req_addr_i),
    .cnt_i(req_count_i), .hdr_o(hdr_w)
  );

  rcf_echo_chk u_echo (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(acc), .hs_i(hs), .chk_i(chk_en),
    .tx_i(tx_byte_o), .rx_i(rx_byte_i), .err_o(chk_err)
  );

  rcf_rd_collect u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .en_i(hs && !wr_q && idx_q >= IDX_W'(8)),
    .word_end_i(pos == 2'd3), .rx_i(rx_byte_i),
    .word_o(rdata_o), .valid_o(rdata_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      cnt_q  <= '0;
      hdr_q  <= '0;
      word_q <= '0;
      idx_q  <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (acc) begin
        if (cnt_ok) begin
          busy_q <= 1'b1;
          wr_q   <= req_write_i;
          cnt_q  <= req_count_i;
          hdr_q  <= hdr_w;
          idx_q  <= '0;
        end else begin
          done_o <= 1'b1;
          err_o  <= 1'b1;
        end
      end
      if (hs) begin
        idx_q <= idx_q + IDX_W'(1);
        if (take) word_q <= wdata_i;
        if (last) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
          err_o  <= chk_err;
        end
      end
    end
  end
endmodule

// File: rtl/reg_cmd_framer_chk.sv
module reg_cmd_framer_chk #(
  parameter int CNT_W   = 8,
  parameter int CNT_MAX = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_write_i,
  input logic [CNT_W-1:0] req_count_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic             xfer_valid_o,
  input logic             xfer_ready_i,
  input logic [7:0]       tx_byte_o,
  input logic             rdata_valid_o
);
  logic        acc, bad, wr_l;
  logic [CNT_W+2:0] n_q;

  assign acc = req_valid_i && !busy_o;
  assign bad = (req_count_i == '0) || (int'(req_count_i) > CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_l <= 1'b0;
      n_q  <= '0;
    end else if (acc) begin
      wr_l <= req_write_i;
      n_q  <= '0;
    end else if (xfer_valid_o && xfer_ready_i) begin
      n_q <= n_q + 1'b1;
    end
  end

  AST_REJECT_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && bad |=> done_o && err_o && !busy_o); // R4
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R10
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R10
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o && !xfer_ready_i |=> xfer_valid_o && $stable(tx_byte_o)); // R11
  AST_RD_ZERO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o && !wr_l && n_q >= 4 |-> tx_byte_o == 8'h00); // R6
  AST_RDATA_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |-> !wr_l); // R9
endmodule

bind reg_cmd_framer reg_cmd_framer_chk #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
  .req_count_i(req_count_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .xfer_valid_o(xfer_valid_o), .xfer_ready_i(xfer_ready_i), .tx_byte_o(tx_byte_o),
  .rdata_valid_o(rdata_valid_o)
);

// File: tb/reg_cmd_framer_tb.sv
`timescale 1ns/1ps
module reg_cmd_framer_tb;
  localparam int NV = 9;
  localparam int NONE = 1023;
  // {wr, mms, addr, count, corrupt slot, stall}
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 4'h1, 16'h0004, 8'd1, 10'd1023, 1'b0},
    {1'b0, 4'h0, 16'h0008, 8'd1, 10'd1023, 1'b1},
    {1'b1, 4'h4, 16'hCA10, 8'd3, 10'd1023, 1'b1},
    {1'b0, 4'h2, 16'h0100, 8'd4, 10'd1023, 1'b0},
    {1'b1, 4'h3, 16'h0020, 8'd2, 10'd9,    1'b0},
    {1'b1, 4'h0, 16'h0003, 8'd1, 10'd7,    1'b1},
    {1'b0, 4'h5, 16'h00FF, 8'd2, 10'd5,    1'b0},
    {1'b0, 4'h6, 16'h1234, 8'd2, 10'd10,   1'b0},
    {1'b1, 4'hF, 16'hFFFF, 8'd2, 10'd2,    1'b1}
  };

  logic clk_i = 0, rst_ni = 0;
  logic req_valid_i = 0, req_write_i = 0;
  logic [3:0] req_mms_i = 0;
  logic [15:0] req_addr_i = 0;
  logic [7:0] req_count_i = 0;
  logic [31:0] wdata_i = 0;
  logic xfer_ready_i = 0;
  logic [7:0] rx_byte_i = 0;
  logic wdata_take_o, busy_o, done_o, err_o, rdata_valid_o, xfer_valid_o;
  logic [31:0] rdata_o;
  logic [7:0] tx_byte_o;

  reg_cmd_framer u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  logic m_wr, m_stall, rdy_t, w_pend;
  logic [15:0] m_addr;
  int m_corrupt, bi, takes, widx, rcount, done_cnt;
  logic err_seen;
  logic [7:0] tx_log [0:1023];
  logic [7:0] rx_log [0:1023];
  logic [31:0] rwords [0:255];

  function automatic logic [31:0] wfun(input logic [15:0] a, input int k);
    return {a ^ 16'h5A5A, 8'(k), 8'(k * 3 + 1)};
  endfunction
  function automatic logic [31:0] rfun(input logic [15:0] a, input int k);
    return {8'hC3 ^ 8'(k), a, 8'(k)};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // peer: echoes sent bytes four slots late, supplies read data
  always @(negedge clk_i) begin
    if (w_pend) begin widx++; wdata_i = wfun(m_addr, widx); w_pend = 0; end
    rdy_t = m_stall ? ~rdy_t : 1'b1;
    xfer_ready_i = rdy_t;
    #1;
    if (rdy_t && xfer_valid_o) begin
      logic [7:0] rb;
      logic [31:0] rw;
      tx_log[bi] = tx_byte_o;
      if (bi < 4) rb = 8'h00;
      else if (m_wr || bi < 8) rb = tx_log[bi-4];
      else begin
        rw = rfun(m_addr, (bi - 8) / 4);
        rb = rw[8*(3-((bi-8)%4)) +: 8];
      end
      if (bi == m_corrupt) rb = rb ^ 8'hFF;
      rx_log[bi] = rb;
      rx_byte_i = rb;
      bi++;
    end
    if (wdata_take_o) begin takes++; w_pend = 1; end
    if (rdata_valid_o) begin rwords[rcount] = rdata_o; rcount++; end
    if (done_o) begin done_cnt++; err_seen = err_o; end
  end

  task automatic run_txn(input logic wr, input logic [3:0] mms, input logic [15:0] addr,
                         input logic [7:0] cnt, input int corrupt, input logic stall, input logic hold_junk);
    int start, guard;
    @(negedge clk_i); #2;
    m_wr = wr; m_addr = addr; m_corrupt = corrupt; m_stall = stall;
    bi = 0; takes = 0; widx = 0; rcount = 0; w_pend = 0; err_seen = 0;
    wdata_i = wfun(addr, 0);
    start = done_cnt;
    req_valid_i = 1; req_write_i = wr; req_mms_i = mms; req_addr_i = addr; req_count_i = cnt;
    @(negedge clk_i); #2;
    if (hold_junk) begin
      req_write_i = ~wr; req_mms_i = ~mms; req_addr_i = ~addr; req_count_i = 8'd7;
    end else req_valid_i = 0;
    guard = 0;
    while (done_cnt == start && guard < 3000) begin @(negedge clk_i); #2; guard++; end
    req_valid_i = 0;
    if (guard >= 3000) chk(1'b0, "R10 watchdog", 32'(guard), 32'd0);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic check_txn(input logic wr, input logic [3:0] mms, input logic [15:0] addr,
                           input int cnt, input int corrupt);
    logic [31:0] h, got, expw;
    int total;
    logic exp_err;
    total = 4 * (cnt + 2);
    h = {1'b0, 1'b0, wr, 1'b0, mms, addr, 7'(cnt - 1), 1'b0};
    h[0] = ~(^h[31:1]);
    got = {tx_log[0], tx_log[1], tx_log[2], tx_log[3]};
    chk(bi == total, "R3 byte count", 32'(bi), 32'(total));
    chk(got == h, "R1 header", got, h);
    chk(($countones(got) % 2) == 1, "R2 odd parity", 32'($countones(got)), 32'd1);
    for (int k = 0; k < 4; k++)
      chk(tx_log[total-4+k] == 8'h00, "R3 filler", 32'(tx_log[total-4+k]), 0);
    if (wr) begin
      chk(takes == cnt, "R5 take count", 32'(takes), 32'(cnt));
      for (int k = 0; k < cnt; k++) begin
        expw = wfun(addr, k);
        got = {tx_log[4+4*k], tx_log[5+4*k], tx_log[6+4*k], tx_log[7+4*k]};
        chk(got == expw, "R5 write word", got, expw);
      end
      exp_err = corrupt >= 4 && corrupt < total;
      chk(err_seen == exp_err, "R7 write echo error", 32'(err_seen), 32'(exp_err));
    end else begin
      for (int k = 4; k < total; k++)
        chk(tx_log[k] == 8'h00, "R6 read zero slot", 32'(tx_log[k]), 0);
      chk(rcount == cnt, "R9 read word count", 32'(rcount), 32'(cnt));
      for (int k = 0; k < cnt && k < rcount; k++) begin
        expw = {rx_log[8+4*k], rx_log[9+4*k], rx_log[10+4*k], rx_log[11+4*k]};
        chk(rwords[k] == expw, "R9 read word", rwords[k], expw);
      end
      exp_err = corrupt >= 4 && corrupt < 8;
      chk(err_seen == exp_err, "R8 read echo error", 32'(err_seen), 32'(exp_err));
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int dc;
    m_wr = 0; m_stall = 0; rdy_t = 1; w_pend = 0; m_addr = 0; m_corrupt = NONE;
    bi = 0; takes = 0; widx = 0; rcount = 0; done_cnt = 0; err_seen = 0;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !err_o && !xfer_valid_o && !rdata_valid_o,
        "R10 reset state", {busy_o, done_o, err_o, xfer_valid_o, rdata_valid_o}, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);

    for (int v = 0; v < NV; v++) begin
      run_txn(VEC[v][39], VEC[v][38:35], VEC[v][34:19], VEC[v][18:11], int'(VEC[v][10:1]), VEC[v][0], 1'b0);
      check_txn(VEC[v][39], VEC[v][38:35], VEC[v][34:19], int'(VEC[v][18:11]), int'(VEC[v][10:1]));
    end

    // R4: out-of-range counts refused with no exchange
    foreach (VEC[i]) ;
    begin
      logic [7:0] bad [3] = '{8'd0, 8'd129, 8'd255};
      for (int b = 0; b < 3; b++) begin
        dc = done_cnt;
        run_txn(1'b1, 4'h2, 16'h0040, bad[b], NONE, 1'b0, 1'b0);
        chk(bi == 0, "R4 no bytes on refusal", 32'(bi), 0);
        chk(done_cnt == dc + 1 && err_seen, "R4 refusal done+err", {done_cnt[15:0], 15'd0, err_seen}, {16'(dc + 1), 16'd1});
      end
    end

    // R9/R3 boundary: 128-register read
    run_txn(1'b0, 4'h1, 16'h0200, 8'd128, NONE, 1'b0, 1'b0);
    check_txn(1'b0, 4'h1, 16'h0200, 128, NONE);
    chk(rwords[127] == rfun(16'h0200, 127), "R9 last word of max read", rwords[127], rfun(16'h0200, 127));

    // R10: requests held during busy are ignored
    dc = done_cnt;
    run_txn(1'b1, 4'h7, 16'h0A0A, 8'd2, NONE, 1'b1, 1'b1);
    check_txn(1'b1, 4'h7, 16'h0A0A, 2, NONE);
    chk(done_cnt == dc + 1, "R10 single done while busy", 32'(done_cnt), 32'(dc + 1));
    chk(!busy_o && bi == 16, "R10 no junk transaction", 32'(bi), 32'd16);

    // R11 exercised through stalled vectors; final idle state
    chk(!xfer_valid_o, "R11 idle after stalls", 32'(xfer_valid_o), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule